// File: doc/BRIEF.md
# UART Line Status and Modem Control

This block keeps the line status word of a memory-mapped UART and drives its two active-low modem control pins. A receiver reports each finished character with a completion strobe and tells the block the sampled stop bit, whether parity mismatched and whether its buffer is full. The block also watches the serial input level on every bit sampling tick. A transmitter supplies two busy levels: one for the holding register or FIFO and one for the shift register. Software reads a 32-bit status word. The error flags in that word are sticky and clear when the word is read. Software also writes a two-bit control value that sets the RTS and DTR pins.

The block contains two receive-side sequences. Break detection counts consecutive low samples. Once a whole frame of them has been seen, it reports a single zero character and then stays locked until the line goes high. Framing-error recovery treats a low line at a bad stop bit as the start of the next character. It samples that level a second time on the next bit tick, and only then asks the receiver to restart on it.

Top module: `uart_line_status`

## Requirements
- R1: The status word carries, from bit 0 up: data ready, overrun, parity error, framing error, break, transmit holding empty, transmitter empty. Bits 31 down to 7 are always zero.
- R2: While reset is asserted and right after it, the status word is 0x00000060, and rtsN and dtrN are both 1.
- R3: One clock after an edge, bit 5 equals the inverse of the txHoldBusy level sampled at that edge.
- R4: One clock after an edge, bit 6 is 1 only if txHoldBusy and txShiftBusy were both 0 at that edge.
- R5: A stored character (rxStore high) sets bit 0 at the next edge. A cycle with rxDataRead high and no store clears it. When both happen together, the store wins.
- R6: A character that completes while bit 0 is set or rxBufFull is high sets bit 1. That character is not stored, so rxStore stays 0.
- R7: An accepted completion with rxParityBad high sets bit 2.
- R8: An accepted completion with rxStopBit low sets bit 3.
- R9: Bits 1 to 4 are sticky. A cycle with statusRd high clears them at the next edge, except a bit that is being set in the same cycle, which stays 1.
- R10: When rxBitTick samples rxSerialIn low for FRAME_BITS consecutive ticks (11 with the default settings), the last of those ticks sets bit 4 and counts as exactly one zero character: it is stored through rxStore, or it sets overrun.
- R11: Once a break has been reported, rxCharDone strobes are ignored, and no further break is reported, until a tick samples the line high.
- R12: If a framing error is accepted while rxSerialIn is low, the next rxBitTick that samples the line low raises rxResync for that one cycle. If that tick samples the line high, nothing happens. A break cancels a pending resync.
- R13: Writing with mcrWe loads mcrWdata. Bit 0 set drives dtrN to 0 and bit 1 set drives rtsN to 0; a cleared bit drives its pin to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxBitTick | input | 1 | One pulse per bit sampling point |
| rxSerialIn | input | 1 | Serial input level |
| rxCharDone | input | 1 | Receiver finished a character |
| rxStopBit | input | 1 | Sampled stop bit, valid with rxCharDone |
| rxParityBad | input | 1 | Parity mismatch, valid with rxCharDone |
| rxBufFull | input | 1 | Receive buffer cannot take a character |
| rxDataRead | input | 1 | Software read of received data |
| statusRd | input | 1 | Software read of the status word |
| txHoldBusy | input | 1 | Holding register or transmit FIFO has data |
| txShiftBusy | input | 1 | Transmit shift register is sending |
| mcrWe | input | 1 | Modem control write strobe |
| mcrWdata | input | 2 | Modem control write value (bit 0 DTR, bit 1 RTS) |
| statusWord | output | 32 | Line status word |
| rxStore | output | 1 | The current character or break is stored |
| rxResync | output | 1 | Receiver should restart on the current low level |
| rtsN | output | 1 | Request to send, active low |
| dtrN | output | 1 | Data terminal ready, active low |

## Verification
The assertions assume that rxBitTick and rxCharDone are single-cycle pulses. They also assume that rxStopBit and rxParityBad only matter while rxCharDone is high, and that mcrWe is a strobe whose data is stable in the same cycle. The stimulus drives every input from one task, once per cycle just after the falling edge, and lowers all strobes again before the next cycle. The serial line only changes on cycles chosen by the scenarios, so the break counter and the resync sequence see a clean sequence of samples.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  typedef struct packed {
    logic store;
    logic setOe;
    logic setPe;
    logic setFe;
    logic setBi;
  } lsrStrobes_t;
endpackage

// File: rtl/lsr_rx_ctrl.sv
module lsr_rx_ctrl
  import uart_lsr_pkg::*;
#(
  parameter int FRAME_BITS = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxBitTick,
  input  logic        rxSerialIn,
  input  logic        rxCharDone,
  input  logic        rxStopBit,
  input  logic        rxParityBad,
  input  logic        rxBufFull,
  input  logic        dataReady,
  output lsrStrobes_t strb,
  output logic        rxResync
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] lowCnt;
  logic armed;
  logic locked, breakEvt, charOk, anyChar, overrun, feLow;

  // A saturated counter is the lock: no further break, no completions.
  assign locked   = (lowCnt == FULL);
  assign breakEvt = rxBitTick && !rxSerialIn && (lowCnt == LAST);
  assign charOk   = rxCharDone && !locked && !breakEvt;
  assign anyChar  = charOk || breakEvt;
  assign overrun  = anyChar && (dataReady || rxBufFull);
  assign feLow    = charOk && !rxStopBit && !rxSerialIn;

  always_comb begin
    strb.store = anyChar && !overrun;
    strb.setOe = overrun;
    strb.setPe = charOk && rxParityBad;
    strb.setFe = charOk && !rxStopBit;
    strb.setBi = breakEvt;
  end

  assign rxResync = armed && rxBitTick && !rxSerialIn && !breakEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (rxBitTick) begin
      if (rxSerialIn) lowCnt <= '0;
      else if (!locked) lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else if (breakEvt) armed <= 1'b0;
    else if (feLow) armed <= 1'b1;
    else if (rxBitTick) armed <= 1'b0;
  end

  AST_RESYNC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxResync && !rxCharDone |=> !rxResync); // R12
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBi |=> !strb.setBi && !strb.setFe); // R11
  AST_BREAK_ONE_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBi |-> (strb.store != strb.setOe)); // R10
endmodule

// File: rtl/lsr_status_path.sv
module lsr_status_path
  import uart_lsr_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int MCR_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  lsrStrobes_t         strb,
  input  logic                rxDataRead,
  input  logic                statusRd,
  input  logic                txHoldBusy,
  input  logic                txShiftBusy,
  input  logic                mcrWe,
  input  logic [MCR_W-1:0]    mcrWdata,
  output logic [STATUS_W-1:0] statusWord,
  output logic                dataReady,
  output logic                rtsN,
  output logic                dtrN
);
  localparam int NSTICKY = 4;
  localparam int PAD_W   = STATUS_W - 3 - NSTICKY;

  logic [NSTICKY-1:0] stickySet, sticky;
  logic holdEmpty, txEmpty;
  logic [MCR_W-1:0] mcr;

  // order: overrun, parity, framing, break
  assign stickySet = {strb.setBi, strb.setFe, strb.setPe, strb.setOe};

  for (genvar i = 0; i < NSTICKY; i++) begin : gSticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sticky[i] <= 1'b0;
      else if (stickySet[i]) sticky[i] <= 1'b1;
      else if (statusRd) sticky[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReady <= 1'b0;
      holdEmpty <= 1'b1;
      txEmpty   <= 1'b1;
      mcr       <= '0;
    end else begin
      if (strb.store) dataReady <= 1'b1;
      else if (rxDataRead) dataReady <= 1'b0;
      holdEmpty <= !txHoldBusy;
      txEmpty   <= !txHoldBusy && !txShiftBusy;
      if (mcrWe) mcr <= mcrWdata;
    end
  end

  assign statusWord = {{PAD_W{1'b0}}, txEmpty, holdEmpty, sticky, dataReady};
  assign dtrN = !mcr[0];
  assign rtsN = !mcr[1];

  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[6] |-> statusWord[5]); // R4
  AST_STORE_SETS_READY: assert property (@(posedge clk) disable iff (!rstN)
    strb.store |=> dataReady); // R5
  AST_STICKY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    statusRd && !strb.setPe |=> !statusWord[2]); // R9
  AST_DTR_PIN: assert property (@(posedge clk) disable iff (!rstN)
    mcrWe |=> (dtrN == !$past(mcrWdata[0]))); // R13
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_lsr_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int PARITY_BITS = 1,
  parameter int STOP_BITS   = 1,
  parameter int STATUS_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxBitTick,
  input  logic                rxSerialIn,
  input  logic                rxCharDone,
  input  logic                rxStopBit,
  input  logic                rxParityBad,
  input  logic                rxBufFull,
  input  logic                rxDataRead,
  input  logic                statusRd,
  input  logic                txHoldBusy,
  input  logic                txShiftBusy,
  input  logic                mcrWe,
  input  logic [1:0]          mcrWdata,
  output logic [STATUS_W-1:0] statusWord,
  output logic                rxStore,
  output logic                rxResync,
  output logic                rtsN,
  output logic                dtrN
);
  localparam int FRAME_BITS = 1 + DATA_BITS + PARITY_BITS + STOP_BITS;

  lsrStrobes_t strb;
  logic dataReady;

  lsr_rx_ctrl #(.FRAME_BITS(FRAME_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .rxBitTick(rxBitTick), .rxSerialIn(rxSerialIn),
    .rxCharDone(rxCharDone), .rxStopBit(rxStopBit), .rxParityBad(rxParityBad),
    .rxBufFull(rxBufFull), .dataReady(dataReady), .strb(strb), .rxResync(rxResync)
  );

  lsr_status_path #(.STATUS_W(STATUS_W), .MCR_W(2)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .rxDataRead(rxDataRead),
    .statusRd(statusRd), .txHoldBusy(txHoldBusy), .txShiftBusy(txShiftBusy),
    .mcrWe(mcrWe), .mcrWdata(mcrWdata), .statusWord(statusWord),
    .dataReady(dataReady), .rtsN(rtsN), .dtrN(dtrN)
  );

  assign rxStore = strb.store;
endmodule

// File: tb/uart_line_status_test.sv
module uart_line_status_test;
  localparam int FRAME = 11;

  logic clk = 0, rstN = 0;
  logic tick = 0, sin = 1, done = 0, stopB = 1, parBad = 0, bufFull = 0;
  logic dRead = 0, sRd = 0, holdB = 0, shiftB = 0, we = 0;
  logic [1:0] wdata = 0;
  logic [31:0] statusWord;
  logic rxStore, rxResync, rtsN, dtrN;

  int errors = 0, checks = 0;
  int lowCnt = 0;
  bit armed = 0, dr = 0, oe = 0, pe = 0, fe = 0, bi = 0, thre = 1, temt = 1;
  bit [1:0] mcr = 0;
  bit expStore, expResync;
  bit [31:0] captured;

  uart_line_status uut (
    .clk(clk), .rstN(rstN), .rxBitTick(tick), .rxSerialIn(sin), .rxCharDone(done),
    .rxStopBit(stopB), .rxParityBad(parBad), .rxBufFull(bufFull), .rxDataRead(dRead),
    .statusRd(sRd), .txHoldBusy(holdB), .txShiftBusy(shiftB), .mcrWe(we),
    .mcrWdata(wdata), .statusWord(statusWord), .rxStore(rxStore),
    .rxResync(rxResync), .rtsN(rtsN), .dtrN(dtrN)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpRegs();
    chk("R1 upper bits", {7'd0, statusWord[31:7]}, 32'd0);
    chk("R5 data ready", statusWord[0], dr);
    chk("R6 overrun", statusWord[1], oe);
    chk("R7 parity", statusWord[2], pe);
    chk("R8 framing", statusWord[3], fe);
    chk("R10 break", statusWord[4], bi);
    chk("R3 thre", statusWord[5], thre);
    chk("R4 temt", statusWord[6], temt);
    chk("R13 dtrN", dtrN, !mcr[0]);
    chk("R13 rtsN", rtsN, !mcr[1]);
  endtask

  // One clock: inputs already set just after a falling edge.
  task automatic cycle();
    bit brk, ok, anyC, ovr, feL;
    #1;
    brk = tick && !sin && !bi_locked() && lowCnt == FRAME - 1;
    ok = done && lowCnt != FRAME && !brk;
    anyC = ok || brk;
    ovr = anyC && (dr || bufFull);
    feL = ok && !stopB && !sin;
    expStore = anyC && !ovr;
    expResync = armed && tick && !sin && !brk;
    chk("R6/R10 rxStore", rxStore, expStore);
    chk("R12 rxResync", rxResync, expResync);
    if (ovr) oe = 1; else if (sRd) oe = 0;
    if (ok && parBad) pe = 1; else if (sRd) pe = 0;
    if (ok && !stopB) fe = 1; else if (sRd) fe = 0;
    if (brk) bi = 1; else if (sRd) bi = 0;
    if (expStore) dr = 1; else if (dRead) dr = 0;
    thre = !holdB;
    temt = !holdB && !shiftB;
    if (we) mcr = wdata;
    if (brk) armed = 0; else if (feL) armed = 1; else if (tick) armed = 0;
    if (tick) begin
      if (sin) lowCnt = 0; else if (lowCnt < FRAME) lowCnt++;
    end
    @(negedge clk);
    captured = statusWord;
    cmpRegs();
    tick = 0; done = 0; stopB = 1; parBad = 0; dRead = 0; sRd = 0; we = 0;
  endtask

  function automatic bit bi_locked();
    return lowCnt == FRAME;
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset word", statusWord, 32'h60);
    chk("R2 reset pins", {30'd0, rtsN, dtrN}, 32'd3);
    rstN = 1;
    @(negedge clk);
    cmpRegs();

    // transmitter states (R3, R4)
    holdB = 1; idle(2);
    chk("R3 thre low when holding busy", captured[5], 0);
    holdB = 0; shiftB = 1; idle(2);
    chk("R4 temt low while shifting", captured[6], 0);
    shiftB = 0; idle(1);

    // good char, read (R5)
    done = 1; cycle();
    chk("R5 ready after char", captured[0], 1);
    dRead = 1; cycle();
    chk("R5 ready cleared", captured[0], 0);
    // store and read together: store wins
    done = 1; dRead = 1; cycle();
    chk("R5 store wins over read", captured[0], 1);

    // overrun (R6)
    done = 1; cycle();
    chk("R6 overrun set", captured[1], 1);
    dRead = 1; sRd = 1; cycle();
    bufFull = 1; done = 1; cycle();
    chk("R6 overrun on full buffer", captured[1:0], 2'b10);
    bufFull = 0; sRd = 1; cycle();

    // parity and framing with line high (R7, R8)
    done = 1; parBad = 1; stopB = 0; cycle();
    chk("R7 parity set", captured[2], 1);
    chk("R8 framing set", captured[3], 1);
    tick = 1; cycle();
    // read with a concurrent set (R9)
    sRd = 1; dRead = 1; done = 1; parBad = 1; cycle();
    chk("R9 set wins over clear", captured[3:2], 2'b01);
    sRd = 1; cycle();
    chk("R9 cleared", captured[4:1], 0);

    // framing error with line low, confirmed (R12)
    dRead = 1; cycle();
    sin = 0; done = 1; stopB = 0; cycle();
    idle(2);
    tick = 1; cycle();
    dRead = 1; sRd = 1; sin = 1; tick = 1; cycle();
    // not confirmed
    sin = 0; done = 1; stopB = 0; cycle();
    sin = 1; tick = 1; cycle();
    idle(1);
    dRead = 1; sRd = 1; cycle();

    // break (R10, R11)
    sin = 0;
    for (int i = 0; i < FRAME; i++) begin tick = 1; cycle(); idle(1); end
    chk("R10 break flagged", captured[4], 1);
    chk("R10 zero char stored", captured[0], 1);
    dRead = 1; sRd = 1; cycle();
    done = 1; stopB = 0; cycle();
    chk("R11 completion ignored in break", captured[3:0], 0);
    for (int i = 0; i < FRAME + 2; i++) begin tick = 1; cycle(); end
    chk("R11 no second break", captured[4], 0);
    sin = 1; tick = 1; cycle();
    done = 1; cycle();
    chk("R11 reception resumes", captured[0], 1);

    // modem control (R13)
    we = 1; wdata = 2'b01; cycle();
    chk("R13 dtr asserted", {rtsN, dtrN}, 2'b10);
    we = 1; wdata = 2'b10; cycle();
    chk("R13 rts asserted", {rtsN, dtrN}, 2'b01);
    we = 1; wdata = 2'b00; cycle();
    idle(3);
    finishRun();
  end
endmodule